// File: doc/BRIEF.md
# Multistage Butterfly Interconnect Fabric

This block is a unidirectional indirect network that joins `NUM_PORTS` source channels to `NUM_PORTS` sink channels. Traffic passes through a column of radix-`RADIX` wormhole switch nodes for each base-`RADIX` digit of the destination address. The default build has 64 ports and radix 4, so a flit crosses three columns of sixteen 4x4 nodes. Every node is named by its column and its position in that column. Each node reads a single digit of the destination field carried in a packet's head flit and steers the packet to the output with that number. The most significant digit is resolved first. Channels only carry data forward, and the wiring gives exactly one path between any source and any sink.

Every link uses a valid/ready handshake. A flit is `DATA_W+2` bits wide. Bit `DATA_W+1` is the head marker and bit `DATA_W` is the tail marker. A one-flit packet sets both markers. The low `DATA_W` bits are payload. In a head flit, the low `STAGES*log2(RADIX)` payload bits (bits [5:0] by default) hold the destination port number. Each switch output has a one-flit register. When an output has accepted a head, it stays locked to that input until the matching tail has passed. Heads that compete for a free output are served in round-robin order.

Top module: `bfly_fabric`

## Requirements
- R1: In the cycle after synchronous reset is released, every `out_valid` bit is low.
- R2: A packet leaves only on the output whose number equals bits [ADDR_W-1:0] of its head payload, and every flit of the packet is unchanged.
- R3: On any output, the flits of one packet appear in their original order, with nothing else between the head (bit DATA_W+1 set) and the tail (bit DATA_W set).
- R4: Packets from one source to one destination arrive in the order in which they were offered.
- R5: While `out_valid` is high and `out_ready` is low on a port, that port's valid and flit stay unchanged.
- R6: In an idle fabric, a flit accepted at a rising edge is presented at its output after the STAGES-th rising edge, counting the accepting edge (the third edge in the default build).
- R7: When every source sends one packet to the same destination at once, all of those packets are delivered.
- R8: Through an idle path with `out_ready` held high, a packet of L flits leaves on L consecutive cycles.
- R9: A one-flit packet does not hold its path, so packets from other sources that follow it to the same destination get through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | NUM_PORTS | Per-source flit valid |
| in_ready | output | NUM_PORTS | Per-source flit accepted this cycle |
| in_flit | input | NUM_PORTS*(DATA_W+2) | Source flits, port p in slice p |
| out_valid | output | NUM_PORTS | Per-destination flit valid |
| out_ready | input | NUM_PORTS | Per-destination sink can take a flit |
| out_flit | output | NUM_PORTS*(DATA_W+2) | Destination flits, port p in slice p |

## Verification
The bench drives an all-to-one hotspot. An arbiter that skips its pointer update, or that lets a lock hang on a tail, would starve sources or stall the fabric, and the bench would see missing packets. It sends mixed-length packets under random backpressure. A crossbar that drops its lock early would interleave two worms, and a stage register that overwrites a stalled flit would lose or duplicate data. Both errors appear as scoreboard mismatches at the destination. Directed runs measure latency across three columns and the streaming rate of an eight-flit worm. They also send back-to-back one-flit packets to a single sink, which catches a missing register stage, a bubble per flit, or a one-flit packet that locks its output for good. Inverted digit order or a wrong inter-column wiring shows up as packets reaching the wrong sink.

// File: rtl/bfly_pkg.sv
`timescale 1ns/1ps
// Shared constants and elaboration-time helpers for the butterfly fabric.
// Assumes the port count is an exact power of the switch radix.
package bfly_pkg;

    // Number of marker bits (head, tail) prepended to each flit payload.
    localparam int MARK_W = 2;

    // Integer power, used to compute digit weights at elaboration.
    function automatic int ipow(input int base, input int expo);
        int acc;
        acc = 1;
        for (int e = 0; e < expo; e++) acc = acc * base;
        return acc;
    endfunction

    // Number of base-k digits needed to address n ports (switch columns).
    function automatic int digit_count(input int n, input int k);
        int d;
        int v;
        d = 0;
        v = 1;
        while (v < n) begin
            v = v * k;
            d++;
        end
        return d;
    endfunction

endpackage

// File: rtl/bfly_rr_arbiter.sv
`timescale 1ns/1ps
// Round-robin arbiter for one switch output.
// Grants the first requester at or after the priority pointer; the pointer
// moves past the winner only when adv is high. Assumes N is at least 2.
module bfly_rr_arbiter #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         adv,
    output logic [N-1:0] gnt
);
    localparam int IDX_W = $clog2(N);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] win;
    logic [IDX_W-1:0] idx;
    logic             found;

    // Search requesters starting from the pointer.
    always_comb begin
        gnt   = '0;
        win   = '0;
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            idx = IDX_W'((int'(ptr_q) + k) % N);
            if (!found && req[idx]) begin
                found    = 1'b1;
                gnt[idx] = 1'b1;
                win      = idx;
            end
        end
    end

    // Move priority just past the served requester.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (adv && found) begin
            ptr_q <= (win == IDX_W'(N - 1)) ? '0 : win + 1'b1;
        end
    end

endmodule

// File: rtl/bfly_switch.sv
`timescale 1ns/1ps
// Radix-k wormhole switch node with one registered flit per output.
// A head flit is steered by the address digit at payload bit ROUTE_LSB;
// body flits follow the route stored for their input. An output stays
// locked to its input from a multi-flit head until the tail leaves.
// Assumes RADIX is a power of two and that heads carry the routing digit.
module bfly_switch #(
    parameter int RADIX     = 4,
    parameter int DATA_W    = 16,
    parameter int ROUTE_LSB = 0
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic [RADIX-1:0]                            in_vld,
    output logic [RADIX-1:0]                            in_rdy,
    input  logic [RADIX*(DATA_W+bfly_pkg::MARK_W)-1:0]  in_flit,
    output logic [RADIX-1:0]                            out_vld,
    input  logic [RADIX-1:0]                            out_rdy,
    output logic [RADIX*(DATA_W+bfly_pkg::MARK_W)-1:0]  out_flit
);
    localparam int FLIT_W = DATA_W + bfly_pkg::MARK_W;
    localparam int SEL_W  = $clog2(RADIX);
    localparam int HEAD_B = FLIT_W - 1;
    localparam int TAIL_B = FLIT_W - 2;

    logic [FLIT_W-1:0] in_f     [RADIX];
    logic [SEL_W-1:0]  want     [RADIX];
    logic [SEL_W-1:0]  route_q  [RADIX];
    logic [RADIX-1:0]  req      [RADIX];
    logic [RADIX-1:0]  head_req [RADIX];
    logic [RADIX-1:0]  arb_gnt  [RADIX];
    logic [RADIX-1:0]  gnt      [RADIX];
    logic [SEL_W-1:0]  gnt_idx  [RADIX];
    logic [FLIT_W-1:0] sel_f    [RADIX];
    logic [SEL_W-1:0]  owner_q  [RADIX];
    logic [FLIT_W-1:0] obuf_q   [RADIX];
    logic [RADIX-1:0]  load_ok;
    logic [RADIX-1:0]  xfer;
    logic [RADIX-1:0]  arb_adv;
    logic [RADIX-1:0]  lock_q;
    logic [RADIX-1:0]  ovld_q;

    // Unpack input flits and pick the output each input asks for.
    always_comb begin
        for (int i = 0; i < RADIX; i++) begin
            in_f[i] = in_flit[i*FLIT_W +: FLIT_W];
            want[i] = in_f[i][HEAD_B] ? in_f[i][ROUTE_LSB +: SEL_W] : route_q[i];
        end
    end

    // Build per-output request vectors; only heads may compete.
    always_comb begin
        for (int j = 0; j < RADIX; j++) begin
            for (int i = 0; i < RADIX; i++) begin
                req[j][i]      = in_vld[i] && (want[i] == SEL_W'(j));
                head_req[j][i] = req[j][i] && in_f[i][HEAD_B];
            end
        end
    end

    // One arbiter per output.
    for (genvar j = 0; j < RADIX; j++) begin : g_arb
        bfly_rr_arbiter #(.N(RADIX)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (head_req[j]),
            .adv   (arb_adv[j]),
            .gnt   (arb_gnt[j])
        );
    end

    // Resolve grants (lock overrides arbiter), select flits, form readies.
    always_comb begin
        in_rdy = '0;
        for (int j = 0; j < RADIX; j++) begin
            load_ok[j] = !ovld_q[j] || out_rdy[j];
            for (int i = 0; i < RADIX; i++) begin
                gnt[j][i] = lock_q[j] ? (req[j][i] && (owner_q[j] == SEL_W'(i)))
                                      : arb_gnt[j][i];
            end
            xfer[j]    = (|gnt[j]) && load_ok[j];
            arb_adv[j] = xfer[j] && !lock_q[j];
            gnt_idx[j] = '0;
            sel_f[j]   = '0;
            for (int i = 0; i < RADIX; i++) begin
                if (gnt[j][i]) begin
                    gnt_idx[j] = SEL_W'(i);
                    sel_f[j]   = in_f[i];
                end
                if (gnt[j][i] && load_ok[j]) in_rdy[i] = 1'b1;
            end
        end
    end

    // Output registers, wormhole locks and stored per-input routes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovld_q <= '0;
            lock_q <= '0;
            for (int j = 0; j < RADIX; j++) begin
                obuf_q[j]  <= '0;
                owner_q[j] <= '0;
                route_q[j] <= '0;
            end
        end else begin
            for (int j = 0; j < RADIX; j++) begin
                if (load_ok[j]) begin
                    ovld_q[j] <= |gnt[j];
                    if (|gnt[j]) obuf_q[j] <= sel_f[j];
                end
                if (xfer[j]) begin
                    if (sel_f[j][HEAD_B] && !sel_f[j][TAIL_B]) begin
                        lock_q[j]  <= 1'b1;
                        owner_q[j] <= gnt_idx[j];
                    end else if (sel_f[j][TAIL_B]) begin
                        lock_q[j] <= 1'b0;
                    end
                end
            end
            for (int i = 0; i < RADIX; i++) begin
                if (in_vld[i] && in_rdy[i] && in_f[i][HEAD_B]) begin
                    route_q[i] <= in_f[i][ROUTE_LSB +: SEL_W];
                end
            end
        end
    end

    // Drive packed outputs from the output registers.
    always_comb begin
        for (int j = 0; j < RADIX; j++) begin
            out_vld[j]                      = ovld_q[j];
            out_flit[j*FLIT_W +: FLIT_W]    = obuf_q[j];
        end
    end

endmodule

// File: rtl/bfly_fabric.sv
`timescale 1ns/1ps
// Butterfly fabric: STAGES columns of radix-RADIX wormhole switches.
// Channel labels are base-RADIX numbers. Column s resolves digit
// STAGES-1-s (most significant first): a switch is addressed by its
// channel label with that digit removed, and the digit picks the port.
// After the last column the label equals the destination.
// Assumes NUM_PORTS is RADIX raised to an integer power.
module bfly_fabric #(
    parameter int NUM_PORTS = 64,
    parameter int RADIX     = 4,
    parameter int DATA_W    = 16
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    input  logic [NUM_PORTS-1:0]                            in_valid,
    output logic [NUM_PORTS-1:0]                            in_ready,
    input  logic [NUM_PORTS*(DATA_W+bfly_pkg::MARK_W)-1:0]  in_flit,
    output logic [NUM_PORTS-1:0]                            out_valid,
    input  logic [NUM_PORTS-1:0]                            out_ready,
    output logic [NUM_PORTS*(DATA_W+bfly_pkg::MARK_W)-1:0]  out_flit
);
    localparam int FLIT_W       = DATA_W + bfly_pkg::MARK_W;
    localparam int DIG_W        = $clog2(RADIX);
    localparam int STAGES       = bfly_pkg::digit_count(NUM_PORTS, RADIX);
    localparam int SW_PER_STAGE = NUM_PORTS / RADIX;

    logic              lk_vld  [STAGES+1][NUM_PORTS];
    logic              lk_rdy  [STAGES+1][NUM_PORTS];
    logic [FLIT_W-1:0] lk_flit [STAGES+1][NUM_PORTS];

    // Attach the fabric edges to the first and last link columns.
    for (genvar c = 0; c < NUM_PORTS; c++) begin : g_edge
        assign lk_vld[0][c]                 = in_valid[c];
        assign lk_flit[0][c]                = in_flit[c*FLIT_W +: FLIT_W];
        assign in_ready[c]                  = lk_rdy[0][c];
        assign out_valid[c]                 = lk_vld[STAGES][c];
        assign out_flit[c*FLIT_W +: FLIT_W] = lk_flit[STAGES][c];
        assign lk_rdy[STAGES][c]            = out_ready[c];
    end

    // Place switch columns and wire each port to its channel label.
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        localparam int POS = STAGES - 1 - s;
        localparam int LOW = bfly_pkg::ipow(RADIX, POS);
        for (genvar w = 0; w < SW_PER_STAGE; w++) begin : g_sw
            localparam int BASE = (w / LOW) * LOW * RADIX + (w % LOW);

            logic [RADIX-1:0]        sw_iv;
            logic [RADIX-1:0]        sw_ir;
            logic [RADIX*FLIT_W-1:0] sw_if;
            logic [RADIX-1:0]        sw_ov;
            logic [RADIX-1:0]        sw_or;
            logic [RADIX*FLIT_W-1:0] sw_of;

            for (genvar q = 0; q < RADIX; q++) begin : g_port
                assign sw_iv[q]                        = lk_vld[s][BASE + q*LOW];
                assign sw_if[q*FLIT_W +: FLIT_W]       = lk_flit[s][BASE + q*LOW];
                assign lk_rdy[s][BASE + q*LOW]         = sw_ir[q];
                assign lk_vld[s+1][BASE + q*LOW]       = sw_ov[q];
                assign lk_flit[s+1][BASE + q*LOW]      = sw_of[q*FLIT_W +: FLIT_W];
                assign sw_or[q]                        = lk_rdy[s+1][BASE + q*LOW];
            end

            bfly_switch #(
                .RADIX     (RADIX),
                .DATA_W    (DATA_W),
                .ROUTE_LSB (POS * DIG_W)
            ) u_sw (
                .clk      (clk),
                .rst_n    (rst_n),
                .in_vld   (sw_iv),
                .in_rdy   (sw_ir),
                .in_flit  (sw_if),
                .out_vld  (sw_ov),
                .out_rdy  (sw_or),
                .out_flit (sw_of)
            );
        end
    end

endmodule

// File: rtl/bfly_fabric_chk.sv
`timescale 1ns/1ps
// Protocol checker for the fabric's output side, bound to bfly_fabric.
// Tracks per-port packet framing and checks stall stability and routing.
module bfly_fabric_chk #(
    parameter int NUM_PORTS = 64,
    parameter int RADIX     = 4,
    parameter int DATA_W    = 16
) (
    input logic                                            clk,
    input logic                                            rst_n,
    input logic [NUM_PORTS-1:0]                            out_valid,
    input logic [NUM_PORTS-1:0]                            out_ready,
    input logic [NUM_PORTS*(DATA_W+bfly_pkg::MARK_W)-1:0]  out_flit
);
    localparam int FLIT_W = DATA_W + bfly_pkg::MARK_W;
    localparam int ADDR_W = bfly_pkg::digit_count(NUM_PORTS, RADIX) * $clog2(RADIX);

    logic [NUM_PORTS-1:0] open_q;

    // Track whether each output is between a head and its tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= '0;
        end else begin
            for (int o = 0; o < NUM_PORTS; o++) begin
                if (out_valid[o] && out_ready[o]) begin
                    if (out_flit[o*FLIT_W + FLIT_W-2]) open_q[o] <= 1'b0;
                    else if (out_flit[o*FLIT_W + FLIT_W-1]) open_q[o] <= 1'b1;
                end
            end
        end
    end

    // R1: outputs are idle right after reset is released.
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (out_valid == '0))
        else $error("a_r1_idle_after_reset");

    for (genvar o = 0; o < NUM_PORTS; o++) begin : g_port
        // R5: a stalled output keeps its flit.
        a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[o] && !out_ready[o]) |=>
                (out_valid[o] && $stable(out_flit[o*FLIT_W +: FLIT_W])))
            else $error("a_r5_hold_on_stall port %0d", o);

        // R2: a head leaves only on the port its address names.
        a_r2_right_exit: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[o] && out_flit[o*FLIT_W + FLIT_W-1]) |->
                (out_flit[o*FLIT_W +: ADDR_W] == ADDR_W'(o)))
            else $error("a_r2_right_exit port %0d", o);

        // R3: heads only start packets, bodies only continue them.
        a_r3_framing: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] |-> (out_flit[o*FLIT_W + FLIT_W-1] == !open_q[o]))
            else $error("a_r3_framing port %0d", o);
    end

endmodule

bind bfly_fabric bfly_fabric_chk #(
    .NUM_PORTS (NUM_PORTS),
    .RADIX     (RADIX),
    .DATA_W    (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_flit  (out_flit)
);

// File: tb/bfly_fabric_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: send_pkt queues flits per source and expectations per
// (destination, source); a monitor pops and compares at each output.
module bfly_fabric_tb_top;
    localparam int NP = 64;
    localparam int DW = 16;
    localparam int FW = DW + 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NP-1:0]     in_valid;
    logic [NP-1:0]     in_ready;
    logic [NP*FW-1:0]  in_flit;
    logic [NP-1:0]     out_valid;
    logic [NP-1:0]     out_ready;
    logic [NP*FW-1:0]  out_flit;

    bfly_fabric #(.NUM_PORTS(NP), .RADIX(4), .DATA_W(DW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_flit   (in_flit),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_flit  (out_flit)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [FW-1:0] src_q [NP][$];
    logic [FW-1:0] exp_q [NP*NP][$];
    int seq_cnt  [NP*NP];
    int acc_cyc  [NP];
    int cur_key  [NP];
    bit mid      [NP];
    bit stalled  [NP];
    logic [FW-1:0] stall_f [NP];
    int head_cyc [NP];
    int tail_cyc [NP];
    int last_lat [NP];
    int rx_pkts  [NP];
    int pending = 0;
    int checks  = 0;
    int errors  = 0;
    bit bp_en   = 1'b0;
    bit done    = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Driver: queue a packet at its source and its expectation.
    task automatic send_pkt(input int s, input int d, input int len);
        int key;
        logic [FW-1:0] f;
        key = d*NP + s;
        for (int k = 0; k < len; k++) begin
            if (k == 0) f = {1'b1, (len == 1), 4'(seq_cnt[key]), 6'(s), 6'(d)};
            else        f = {1'b0, (k == len-1), 16'($urandom)};
            src_q[s].push_back(f);
            exp_q[key].push_back(f);
            pending++;
        end
        seq_cnt[key]++;
    endtask

    task automatic drain(input int limit);
        int n;
        n = 0;
        while (pending > 0 && n < limit) begin
            @(posedge clk);
            n++;
        end
        repeat (3) @(posedge clk);
    endtask

    // Monitor: compare every flit that leaves the fabric.
    task automatic monitor();
        logic [FW-1:0] f;
        logic [FW-1:0] e;
        int src;
        int key;
        for (int o = 0; o < NP; o++) begin
            f = out_flit[o*FW +: FW];
            if (stalled[o])
                chk(out_valid[o] && f == stall_f[o], "R5", longint'(f), longint'(stall_f[o]));
            stalled[o] = out_valid[o] && !out_ready[o];
            stall_f[o] = f;
            if (out_valid[o] && out_ready[o]) begin
                pending--;
                if (f[FW-1]) begin
                    chk(!mid[o], "R3", 1, 0);
                    chk(f[5:0] == 6'(o), "R2", longint'(f[5:0]), o);
                    src = int'(f[11:6]);
                    key = o*NP + src;
                    cur_key[o]  = key;
                    head_cyc[o] = cyc;
                    last_lat[o] = cyc - acc_cyc[src];
                    if (exp_q[key].size() == 0) begin
                        chk(1'b0, "R2", longint'(f), 0);
                    end else begin
                        e = exp_q[key].pop_front();
                        chk(f == e, "R4", longint'(f), longint'(e));
                    end
                    mid[o] = !f[FW-2];
                end else begin
                    chk(mid[o], "R3", 0, 1);
                    if (exp_q[cur_key[o]].size() == 0) begin
                        chk(1'b0, "R3", longint'(f), 0);
                    end else begin
                        e = exp_q[cur_key[o]].pop_front();
                        chk(f == e, "R3", longint'(f), longint'(e));
                    end
                end
                if (f[FW-2]) begin
                    mid[o] = 1'b0;
                    rx_pkts[o]++;
                    tail_cyc[o] = cyc;
                end
            end
        end
    endtask

    // Drive at the falling edge, sample just before the rising edge.
    initial begin
        in_valid  = '0;
        in_flit   = '0;
        out_ready = '1;
        forever begin
            @(negedge clk);
            for (int s = 0; s < NP; s++) begin
                in_valid[s] = src_q[s].size() > 0;
                in_flit[s*FW +: FW] = in_valid[s] ? src_q[s][0] : '0;
            end
            for (int o = 0; o < NP; o++)
                out_ready[o] = bp_en ? ($urandom_range(0, 3) != 0) : 1'b1;
            #4;
            monitor();
            for (int s = 0; s < NP; s++) begin
                if (in_valid[s] && in_ready[s]) begin
                    if (src_q[s][0][FW-1]) acc_cyc[s] = cyc;
                    void'(src_q[s].pop_front());
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=0 pending flits", pending);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        int left;
        rst_n = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        #1 chk(out_valid == '0, "R1", longint'(out_valid), 0);

        // R6: latency of one flit through an idle fabric.
        send_pkt(9, 42, 1);
        drain(200);
        chk(last_lat[42] == 3, "R6", last_lat[42], 3);

        // R9: back-to-back one-flit packets to one sink.
        rx_pkts[42] = 0;
        send_pkt(9, 42, 1);
        send_pkt(20, 42, 1);
        send_pkt(9, 42, 1);
        send_pkt(63, 42, 1);
        drain(400);
        chk(rx_pkts[42] == 4, "R9", rx_pkts[42], 4);

        // R8: streaming an eight-flit worm.
        send_pkt(3, 60, 8);
        drain(400);
        chk(tail_cyc[60] - head_cyc[60] == 7, "R8", tail_cyc[60] - head_cyc[60], 7);

        // R7: every source to one sink at once.
        rx_pkts[5] = 0;
        for (int s = 0; s < NP; s++) send_pkt(s, 5, 1 + (s % 3));
        drain(20000);
        chk(rx_pkts[5] == NP, "R7", rx_pkts[5], NP);

        // R4: same-pair ordering, two sources sharing a sink.
        rx_pkts[33] = 0;
        for (int k = 0; k < 8; k++) begin
            send_pkt(17, 33, 1 + (k % 4));
            send_pkt(18, 33, 4 - (k % 4));
        end
        drain(4000);
        chk(rx_pkts[33] == 16, "R4", rx_pkts[33], 16);

        // R2/R3/R5: random traffic under random backpressure.
        bp_en = 1'b1;
        for (int n = 0; n < 800; n++) begin
            send_pkt($urandom_range(0, NP-1), $urandom_range(0, NP-1), $urandom_range(1, 5));
            if (n % 4 == 3) @(posedge clk);
        end
        drain(60000);
        bp_en = 1'b0;
        drain(200);

        left = 0;
        for (int k = 0; k < NP*NP; k++) left += exp_q[k].size();
        chk(left == 0, "R2", left, 0);
        chk(pending == 0, "R2", pending, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule